// File: doc/BRIEF.md
# Three-Wire Register Programming Interface

This block is a slave serial port that lets a host program the control registers of an imaging front end over three wires: an active-low frame select, a serial clock and one data line shared by both directions. The register file holds eight 9-bit registers: a mode register, a channel multiplexer register, three gain registers and three sign-magnitude offset registers. Its outputs are the decoded register fields, which feed the analog front end. The block also drives read data back onto the shared data line. Inside the chip, that line is split into an input, an output and an output enable.

The frame select, the serial clock and the data input are all brought into a single, faster system clock domain. Each one passes through a two-stage synchronizer and an edge detector. The serial interface therefore needs no clock of its own. It must, however, run several times slower than the system clock.

Top module: `cfg_serial_port`

## Requirements
- R1: A frame is 13 bits, sent most significant bit first and sampled on rising serial-clock edges while `sel_n` is low. The bits are: a direction bit (1 = read, 0 = write), address bits A2..A0, and data bits D8..D0. A write takes effect at the 13th rising edge. Any rising edges after the 13th are ignored.
- R2: The addresses are: 0 = mode, 1 = multiplexer, 2/3/4 = red/green/blue gain, 5/6/7 = red/green/blue offset.
- R3: After reset, the mode register reads 0x0F8, the multiplexer register reads 0x0C0, and all gain and offset registers read 0.
- R4: Some bits are forced to 0 on write and read back as 0. These are: D8 and D1 of the mode register; D8 and D3..D0 of the multiplexer register; D8..D6 of each gain register. Offset registers keep all 9 bits.
- R5: In a read frame, the slave drives D8 after the falling serial-clock edge that follows the 4th rising edge. It drives each later data bit after the next falling edge, and each bit is valid at the following rising edge.
- R6: `sdio_oe` is high only during the 9-bit data phase of a read frame. It is low during the header, during every write frame and while `sel_n` is high.
- R7: If `sel_n` rises before the 13th rising edge, the frame is discarded and no register changes.
- R8: Writing the mode register with D2 (power-down) set changes no other register, and every register still reads back its contents.
- R9: The outputs decode the registers as follows:
  - Mode register: `range_4v` = D7, `ref_int` = D6, `three_ch` = D5, `cds_on` = D4, `clamp_4v` = D3, `sleep` = D2, `byte_mode` = D0.
  - Multiplexer register: `order_rgb` = D7, `ch_sel` = D6..D4 (bit 2 = red, bit 1 = green, bit 0 = blue).
  - `gain_vec` = {blue, green, red} D5..D0.
  - `offset_vec` = {blue, green, red} D8..D0, with D8 as the sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_n | input | 1 | Frame select, active low |
| sck | input | 1 | Serial clock |
| sdio_in | input | 1 | Data line, input side |
| sdio_out | output | 1 | Data line, output side |
| sdio_oe | output | 1 | Data line output enable |
| range_4v | output | 1 | Wide input range select |
| ref_int | output | 1 | Internal reference enable |
| three_ch | output | 1 | Three-channel mode |
| cds_on | output | 1 | Double-sampling mode |
| clamp_4v | output | 1 | High clamp level |
| sleep | output | 1 | Power-down |
| byte_mode | output | 1 | Single-byte output mode |
| order_rgb | output | 1 | Channel order red first |
| ch_sel | output | 3 | Channel select {red, green, blue} |
| gain_vec | output | 18 | Gains {blue, green, red}, 6 bits each |
| offset_vec | output | 27 | Offsets {blue, green, red}, 9 bits each |

## Verification
Every serial edge reaches the frame logic three system clocks after it occurs: two synchronizer stages plus one edge-detect stage. So:
- A write appears on the field outputs three clocks after the 13th rising edge.
- A read bit appears on `sdio_out` three clocks after the falling edge that releases it.

The bench holds each serial half period for 8 system clocks and samples `sdio_out` and `sdio_oe` just before it raises the serial clock. It compares the field outputs only after a frame has closed and a gap of 16 clocks has passed, so every result is checked well after it is due and never at an edge.

// File: rtl/cfg_sp_pkg.sv
package cfg_sp_pkg;
    localparam int REG_W     = 9;
    localparam int ADDR_W    = 3;
    localparam int NREG      = 1 << ADDR_W;
    localparam int HDR_LEN   = 1 + ADDR_W;
    localparam int FRAME_LEN = HDR_LEN + REG_W;
    localparam int CNT_W     = $clog2(FRAME_LEN + 1);
    localparam int GAIN_W    = 6;

    typedef enum logic [ADDR_W-1:0] {
        A_MODE   = 3'd0,
        A_MUX    = 3'd1,
        A_GAIN_R = 3'd2,
        A_GAIN_G = 3'd3,
        A_GAIN_B = 3'd4,
        A_OFS_R  = 3'd5,
        A_OFS_G  = 3'd6,
        A_OFS_B  = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [REG_W-1:0]  data;
    } wr_req_t;

    // Writable bits per register; all others are held at zero
    function automatic logic [REG_W-1:0] reg_mask(input int idx);
        case (idx)
            A_MODE:                      return 9'h0FD;
            A_MUX:                       return 9'h0F0;
            A_GAIN_R, A_GAIN_G, A_GAIN_B: return 9'h03F;
            default:                     return 9'h1FF;
        endcase
    endfunction

    function automatic logic [REG_W-1:0] reg_default(input int idx);
        case (idx)
            A_MODE:  return 9'h0F8;
            A_MUX:   return 9'h0C0;
            default: return 9'h000;
        endcase
    endfunction
endpackage

// File: rtl/sp_sync.sv
module sp_sync #(
    parameter int             N       = 3,
    parameter int             STAGES  = 2,
    parameter logic [N-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d,
    output logic [N-1:0] q,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [STAGES-1:0][N-1:0] stg;
    logic [N-1:0]             prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg  <= {STAGES{RST_VAL}};
            prev <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
            prev <= stg[STAGES-1];
        end
    end

    assign q    = stg[STAGES-1];
    assign rise = q & ~prev;
    assign fall = ~q & prev;
endmodule

// File: rtl/sp_frame.sv
module sp_frame
    import cfg_sp_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                sel_act,
    input  logic                sck_rise,
    input  logic                sck_fall,
    input  logic                sdi,
    input  logic [REG_W-1:0]    rd_word,
    output logic [ADDR_W-1:0]   rd_addr,
    output wr_req_t             wr_req,
    output logic                sdo,
    output logic                sdo_oe
);
    localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_LEN - 1);
    localparam logic [CNT_W-1:0] HDR_END  = CNT_W'(HDR_LEN);
    localparam logic [CNT_W-1:0] LAST     = CNT_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0] FULL     = CNT_W'(FRAME_LEN);

    logic [CNT_W-1:0]     cnt;
    logic [REG_W-2:0]     shreg;
    logic                 rw_q;
    logic [ADDR_W-1:0]    addr_q;
    logic [CNT_W-1:0]     bit_idx;

    assign rd_addr = addr_q;
    assign bit_idx = LAST - cnt;

    always_ff @(posedge clk) begin
        if (rst || !sel_act) begin
            cnt    <= '0;
            shreg  <= '0;
            rw_q   <= 1'b0;
            addr_q <= '0;
            sdo    <= 1'b0;
            sdo_oe <= 1'b0;
            wr_req <= '0;
        end else begin
            wr_req.wr <= 1'b0;
            if (sck_rise && cnt < FULL) begin
                cnt   <= cnt + 1'b1;
                shreg <= {shreg[REG_W-3:0], sdi};
                if (cnt == HDR_LAST) begin
                    rw_q   <= shreg[ADDR_W-1];
                    addr_q <= {shreg[ADDR_W-2:0], sdi};
                end
                if (cnt == LAST) begin
                    sdo_oe <= 1'b0;
                    if (!rw_q) begin
                        wr_req.wr   <= 1'b1;
                        wr_req.addr <= addr_q;
                        wr_req.data <= {shreg, sdi};
                    end
                end
            end
            if (sck_fall && rw_q && cnt >= HDR_END && cnt < FULL) begin
                sdo    <= rd_word[bit_idx];
                sdo_oe <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sp_regfile.sv
module sp_regfile
    import cfg_sp_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  wr_req_t                 wr_req,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [REG_W-1:0]        rd_word,
    output logic [NREG*REG_W-1:0]   regs_flat
);
    generate
        for (genvar g = 0; g < NREG; g++) begin : g_reg
            logic [REG_W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= reg_default(g);
                else if (wr_req.wr && wr_req.addr == ADDR_W'(g))
                    q <= wr_req.data & reg_mask(g);
            end
            assign regs_flat[g*REG_W +: REG_W] = q;
        end
    endgenerate

    assign rd_word = regs_flat[rd_addr*REG_W +: REG_W];
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
    import cfg_sp_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   sel_n,
    input  logic                   sck,
    input  logic                   sdio_in,
    output logic                   sdio_out,
    output logic                   sdio_oe,
    output logic                   range_4v,
    output logic                   ref_int,
    output logic                   three_ch,
    output logic                   cds_on,
    output logic                   clamp_4v,
    output logic                   sleep,
    output logic                   byte_mode,
    output logic                   order_rgb,
    output logic [2:0]             ch_sel,
    output logic [3*GAIN_W-1:0]    gain_vec,
    output logic [3*REG_W-1:0]     offset_vec
);
    logic [2:0]                 pin_q, pin_rise, pin_fall;
    logic                       sel_act;
    logic [REG_W-1:0]           rd_word;
    logic [ADDR_W-1:0]          rd_addr;
    logic [NREG*REG_W-1:0]      regs_flat;
    logic                       wr_en;
    wr_req_t                    wr_req;

    sp_sync #(.N(3), .STAGES(2), .RST_VAL(3'b100)) sync_i (
        .clk  (clk),
        .rst  (rst),
        .d    ({sel_n, sck, sdio_in}),
        .q    (pin_q),
        .rise (pin_rise),
        .fall (pin_fall)
    );

    assign sel_act = ~pin_q[2];

    sp_frame frame_i (
        .clk      (clk),
        .rst      (rst),
        .sel_act  (sel_act),
        .sck_rise (pin_rise[1]),
        .sck_fall (pin_fall[1]),
        .sdi      (pin_q[0]),
        .rd_word  (rd_word),
        .rd_addr  (rd_addr),
        .wr_req   (wr_req),
        .sdo      (sdio_out),
        .sdo_oe   (sdio_oe)
    );

    sp_regfile regs_i (
        .clk       (clk),
        .rst       (rst),
        .wr_req    (wr_req),
        .rd_addr   (rd_addr),
        .rd_word   (rd_word),
        .regs_flat (regs_flat)
    );

    assign wr_en = wr_req.wr;

    logic [REG_W-1:0] mode_r, mux_r;
    assign mode_r = regs_flat[A_MODE*REG_W +: REG_W];
    assign mux_r  = regs_flat[A_MUX*REG_W  +: REG_W];

    assign range_4v  = mode_r[7];
    assign ref_int   = mode_r[6];
    assign three_ch  = mode_r[5];
    assign cds_on    = mode_r[4];
    assign clamp_4v  = mode_r[3];
    assign sleep     = mode_r[2];
    assign byte_mode = mode_r[0];
    assign order_rgb = mux_r[7];
    assign ch_sel    = mux_r[6:4];

    generate
        for (genvar c = 0; c < 3; c++) begin : g_chan
            assign gain_vec[c*GAIN_W +: GAIN_W] =
                regs_flat[(A_GAIN_R + c)*REG_W +: GAIN_W];
            assign offset_vec[c*REG_W +: REG_W] =
                regs_flat[(A_OFS_R + c)*REG_W +: REG_W];
        end
    endgenerate
endmodule

// File: rtl/sp_chk.sv
module sp_chk
    import cfg_sp_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    sel_act,
    input logic                    oe,
    input logic                    wr_en,
    input logic [NREG*REG_W-1:0]   regs
);
    AST_OE_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        oe |-> sel_act);                                              // R6
    AST_WR_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> sel_act);                                           // R1
    AST_ONE_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);                                            // R1
    AST_REGS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(regs));                                    // R7
    AST_MODE_RSVD: assert property (@(posedge clk) disable iff (rst)
        regs[8] == 1'b0 && regs[1] == 1'b0);                          // R4
    AST_MUX_RSVD: assert property (@(posedge clk) disable iff (rst)
        regs[17] == 1'b0 && regs[12:9] == 4'd0);                      // R4
    AST_GAIN_RSVD: assert property (@(posedge clk) disable iff (rst)
        regs[26:24] == 3'd0 && regs[35:33] == 3'd0 && regs[44:42] == 3'd0); // R4
endmodule

bind cfg_serial_port sp_chk chk_i (
    .clk     (clk),
    .rst     (rst),
    .sel_act (sel_act),
    .oe      (sdio_oe),
    .wr_en   (wr_en),
    .regs    (regs_flat)
);

// File: tb/cfg_serial_port_tb_top.sv
`timescale 1ns/1ps
module cfg_serial_port_tb_top;
    localparam int HP = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sel_n = 1'b1, sck = 1'b0, sdio_in = 1'b0;
    logic sdio_out, sdio_oe;
    logic range_4v, ref_int, three_ch, cds_on, clamp_4v, sleep, byte_mode, order_rgb;
    logic [2:0]  ch_sel;
    logic [17:0] gain_vec;
    logic [26:0] offset_vec;

    int  n_chk = 0, n_err = 0;
    bit  done = 0;
    logic [8:0] model [8];

    always #4 clk = ~clk;

    cfg_serial_port dut_i (
        .clk(clk), .rst(rst), .sel_n(sel_n), .sck(sck), .sdio_in(sdio_in),
        .sdio_out(sdio_out), .sdio_oe(sdio_oe),
        .range_4v(range_4v), .ref_int(ref_int), .three_ch(three_ch),
        .cds_on(cds_on), .clamp_4v(clamp_4v), .sleep(sleep),
        .byte_mode(byte_mode), .order_rgb(order_rgb), .ch_sel(ch_sel),
        .gain_vec(gain_vec), .offset_vec(offset_vec)
    );

    // {address, written data}; expected read-back is data under the R4 mask
    localparam logic [11:0] VEC [10] = '{
        {3'd0, 9'h1FF}, {3'd1, 9'h1FF}, {3'd2, 9'h1C5}, {3'd3, 9'h03F},
        {3'd4, 9'h12A}, {3'd5, 9'h1FF}, {3'd6, 9'h155}, {3'd7, 9'h0AA},
        {3'd0, 9'h0F8}, {3'd1, 9'h0A0}
    };

    function automatic logic [8:0] mask_of(input int a);
        case (a)
            0: return 9'h0FD;
            1: return 9'h0F0;
            2, 3, 4: return 9'h03F;
            default: return 9'h1FF;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic frame(input logic rw, input logic [2:0] a, input logic [8:0] d,
                         input int nbits, output logic [8:0] rd, output int oe_bad);
        logic [12:0] word;
        word = {rw, a, d};
        rd = '0;
        oe_bad = 0;
        @(negedge clk) sel_n = 1'b0;
        repeat (HP) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            if (i < 13) sdio_in = (rw && i >= 4) ? 1'b0 : word[12-i];
            else        sdio_in = 1'b1;
            repeat (HP) @(negedge clk);
            if (sdio_oe !== (rw && i >= 4 && i < 13)) oe_bad++;
            if (rw && i >= 4 && i < 13) rd[12-i] = sdio_out;
            sck = 1'b1;
            repeat (HP) @(negedge clk);
            sck = 1'b0;
        end
        repeat (HP) @(negedge clk);
        sel_n = 1'b1;
        sdio_in = 1'b0;
        repeat (2*HP) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [8:0] d);
        logic [8:0] dummy;
        int ob;
        frame(1'b0, a, d, 13, dummy, ob);
        chk("R6 oe low in write frame", ob, 0);
        model[a] = d & mask_of(a);
    endtask

    task automatic rd_check(input string tag, input logic [2:0] a);
        logic [8:0] v;
        int ob;
        frame(1'b1, a, 9'h0, 13, v, ob);
        chk(tag, v, model[a]);
        chk("R6 oe only in read data phase", ob, 0);
    endtask

    task automatic port_check(input string tag);
        chk(tag, {range_4v, ref_int, three_ch, cds_on, clamp_4v, sleep, byte_mode},
                 {model[0][7:2], model[0][0]});
        chk(tag, {order_rgb, ch_sel}, model[1][7:4]);
        chk(tag, gain_vec, {model[4][5:0], model[3][5:0], model[2][5:0]});
        chk(tag, offset_vec, {model[7], model[6], model[5]});
    endtask

    initial begin
        for (int k = 0; k < 8; k++) model[k] = 9'h0;
        model[0] = 9'h0F8;
        model[1] = 9'h0C0;
        repeat (10) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R3 reset state at the ports and by read-back; R9 decode
        port_check("R3 R9 reset fields");
        chk("R6 oe low when idle", sdio_oe, 0);
        for (int k = 0; k < 8; k++) rd_check("R3 R5 reset read-back", 3'(k));

        // R2 R4 R5 R9 table of writes
        for (int v = 0; v < 10; v++) begin
            wr_reg(VEC[v][11:9], VEC[v][8:0]);
            rd_check("R2 R4 R5 read-back", VEC[v][11:9]);
            port_check("R9 decoded fields");
        end

        // R7 aborted write after 8 bits leaves register untouched
        begin
            logic [8:0] dummy;
            int ob;
            frame(1'b0, 3'd3, 9'h011, 8, dummy, ob);
            rd_check("R7 aborted frame discarded", 3'd3);
            port_check("R7 fields after abort");
        end

        // R1 rising edges past the 13th are ignored
        begin
            logic [8:0] dummy;
            int ob;
            frame(1'b0, 3'd5, 9'h123, 15, dummy, ob);
            model[5] = 9'h123;
            rd_check("R1 extra edges ignored", 3'd5);
        end

        // R8 power-down keeps every register
        wr_reg(3'd0, 9'h0FC);
        chk("R8 sleep field set", sleep, 1);
        for (int k = 0; k < 8; k++) rd_check("R8 contents kept in power-down", 3'(k));
        port_check("R8 fields in power-down");

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule